// File: doc/BRIEF.md
# Software Strap Configuration Controller

This block lets a host configure a PHY through virtual strap bits instead of physical pins. After a hardware reset the PHY core is held in reset. While it is held, the host writes a strap word at management address 0x09 through a simple register port. That word carries the auto crossover enable, the auto-negotiation enable, a two-bit link mode field and an LED configuration select.

Writing a 1 to the completion flag (bit 15) while the flag is still 0 starts the commit. The block raises a single-cycle internal reset pulse, then releases the core reset hold. When strap override is selected, it also loads the decoded strap fields into three live registers: the basic mode control register (0x00), the advertisement register (0x04) and the PHY control register (0x19). When override is not selected, those registers keep the pin-derived values they captured during hardware reset.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: While and after hardware reset, address 0x09 reads 0x7C00. This means the completion flag (bit 15) is 0, bits 14:10 are 1 and bits 9:0 are 0. Also, `core_rst_hold` is 1, `int_rst_pulse` is 0, and the three live registers equal `pin_bmcr`, `pin_anar` and `pin_phycr`.
- R2: A write to 0x09 updates bits 14:10 from `reg_wdata`, and bits 9:0 always read 0. Reads of 0x00, 0x04 and 0x19 return the live registers. Any other address reads 0.
- R3: A write to 0x09 with bit 15 set while the flag is 0 makes `int_rst_pulse` high for exactly one cycle, the cycle right after the write edge.
- R4: `core_rst_hold` stays 1 until the pulse. It falls the cycle after the pulse and then stays 0.
- R5: Once set, the completion flag can be cleared only by hardware reset. Further writes, including writes of 0 to bit 15, give no pulse and leave the live registers unchanged.
- R6: Under override with negotiation enable (bit 13) at 0, the commit affects the basic mode control register as follows. Bit 12 is cleared. Bit 13 (speed, 1 = 100 Mb) takes mode bit 12. Bit 8 (duplex, 1 = full) takes mode bit 11. The advertisement register is left unchanged. Forced mode values 00/01/10/11 select 10 half, 10 full, 100 half and 100 full.
- R7: Under override with negotiation enable at 1, the commit sets basic mode control bit 12 and clears bits 13 and 8. It writes advertisement bits 5/6/7/8 (10 half, 10 full, 100 half, 100 full) from the mode field. The codes are: 00 gives 10 half and full; 01 gives 100 half and full; 10 gives 10 half and 100 half; 11 gives all four. Other bits are kept.
- R8: Under override, the commit copies strap bit 14 into PHY control bit 15 and strap bit 10 into PHY control bit 5. Other bits are kept.
- R9: Without override, the commit leaves all three live registers unchanged, and the pulse still releases the hold.
- R10: A new hardware reset clears the flag and re-arms the sequence, so that a later 0-to-1 write again gives one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| strap_ovr | input | 1 | 1 = commit strap fields into live registers |
| pin_bmcr | input | 16 | Pin-derived reset value for basic mode control |
| pin_anar | input | 16 | Pin-derived reset value for advertisement |
| pin_phycr | input | 16 | Pin-derived reset value for PHY control |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| core_rst_hold | output | 1 | Holds the PHY core in reset until commit |
| int_rst_pulse | output | 1 | One-cycle internal reset pulse |
| bmcr_q | output | 16 | Live basic mode control register |
| anar_q | output | 16 | Live advertisement register |
| phycr_q | output | 16 | Live PHY control register |

## Verification
The assertions assume that `strap_ovr` and the pin inputs stay steady from reset release until the commit. The stability check treats every non-commit cycle as "no change", so it relies on the live registers not being written at any other time. The bench changes the pins and override only while reset is asserted, and it issues each register write as a single-cycle strobe driven between clock edges. It sweeps all eight enable/mode combinations, both with and without override, and resets between cases.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 5;
  localparam logic [AW-1:0] ADDR_BMCR  = 5'h00;
  localparam logic [AW-1:0] ADDR_ANAR  = 5'h04;
  localparam logic [AW-1:0] ADDR_STRAP = 5'h09;
  localparam logic [AW-1:0] ADDR_PHYCR = 5'h19;
  localparam logic [DW-1:0] STRAP_RST  = 16'h7C00;

  // strap fields below the completion flag
  typedef struct packed {
    logic       mdix_en;
    logic       an_en;
    logic [1:0] mode;
    logic       led_sel;
  } strap_t;

  // basic mode control: bit12 negotiation, bit13 speed, bit8 duplex
  function automatic logic [DW-1:0] bmcr_commit(logic [DW-1:0] cur, strap_t s);
    logic [DW-1:0] r;
    r     = cur;
    r[12] = s.an_en;
    r[13] = s.an_en ? 1'b0 : s.mode[1];
    r[8]  = s.an_en ? 1'b0 : s.mode[0];
    return r;
  endfunction

  // advertisement bits [8:5] = {100F, 100H, 10F, 10H}
  function automatic logic [DW-1:0] anar_commit(logic [DW-1:0] cur, strap_t s);
    logic [DW-1:0] r;
    r = cur;
    if (s.an_en) begin
      case (s.mode)
        2'b00:   r[8:5] = 4'b0011;
        2'b01:   r[8:5] = 4'b1100;
        2'b10:   r[8:5] = 4'b0101;
        default: r[8:5] = 4'b1111;
      endcase
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] phycr_commit(logic [DW-1:0] cur, strap_t s);
    logic [DW-1:0] r;
    r     = cur;
    r[15] = s.mdix_en;
    r[5]  = s.led_sel;
    return r;
  endfunction
endpackage

// File: rtl/strap_reg.sv
module strap_reg
  import strap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [15:10]  wr_bits,
  output logic          done_q,
  output strap_t        strap_q,
  output logic          done_rise
);
  logic [DW-1:0] rst_word;
  assign rst_word = STRAP_RST;

  assign done_rise = wr_hit && wr_bits[15] && !done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= rst_word[15];
      strap_q <= rst_word[14:10];
    end else if (wr_hit) begin
      strap_q <= wr_bits[14:10];
      if (wr_bits[15]) done_q <= 1'b1;
    end
  end

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/strap_seq.sv
module strap_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_rise,
  output logic rst_pulse,
  output logic core_hold,
  output logic commit_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_pulse <= 1'b0;
      core_hold <= 1'b1;
    end else begin
      rst_pulse <= done_rise;
      if (rst_pulse) core_hold <= 1'b0;
    end
  end

  assign commit_en = rst_pulse;

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  // R3
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(done_rise));
  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> $past(rst_pulse));
  // R4
  hold_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_hold |=> !core_hold);
endmodule

// File: rtl/strap_commit.sv
module strap_commit
  import strap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovr,
  input  logic          commit_en,
  input  strap_t        strap,
  input  logic [DW-1:0] pin_bmcr,
  input  logic [DW-1:0] pin_anar,
  input  logic [DW-1:0] pin_phycr,
  output logic [DW-1:0] bmcr_q,
  output logic [DW-1:0] anar_q,
  output logic [DW-1:0] phycr_q
);
  logic do_load;
  assign do_load = commit_en && ovr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bmcr_q  <= pin_bmcr;
      anar_q  <= pin_anar;
      phycr_q <= pin_phycr;
    end else if (do_load) begin
      bmcr_q  <= bmcr_commit(bmcr_q, strap);
      anar_q  <= anar_commit(anar_q, strap);
      phycr_q <= phycr_commit(phycr_q, strap);
    end
  end

  // R9
  live_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_en && ovr) |=> ($stable(bmcr_q) && $stable(anar_q) && $stable(phycr_q)));
  // R6
  an_bit_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && ovr) |=> (bmcr_q[12] == $past(strap.an_en)));
  // R8
  phycr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && ovr) |=> (phycr_q[15] == $past(strap.mdix_en) && phycr_q[5] == $past(strap.led_sel)));
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_ovr,
  input  logic [15:0]   pin_bmcr,
  input  logic [15:0]   pin_anar,
  input  logic [15:0]   pin_phycr,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          core_rst_hold,
  output logic          int_rst_pulse,
  output logic [15:0]   bmcr_q,
  output logic [15:0]   anar_q,
  output logic [15:0]   phycr_q
);
  logic   strap_hit, done_q, done_rise, commit_en;
  strap_t strap_q;
  logic   unused_low_bits;

  assign unused_low_bits = ^reg_wdata[9:0];
  assign strap_hit = reg_we && (reg_addr == ADDR_STRAP);

  strap_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(strap_hit), .wr_bits(reg_wdata[15:10]),
    .done_q(done_q), .strap_q(strap_q), .done_rise(done_rise)
  );

  strap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .done_rise(done_rise),
    .rst_pulse(int_rst_pulse), .core_hold(core_rst_hold), .commit_en(commit_en)
  );

  strap_commit u_commit (
    .clk(clk), .rst_n(rst_n), .ovr(strap_ovr), .commit_en(commit_en), .strap(strap_q),
    .pin_bmcr(pin_bmcr), .pin_anar(pin_anar), .pin_phycr(pin_phycr),
    .bmcr_q(bmcr_q), .anar_q(anar_q), .phycr_q(phycr_q)
  );

  always_comb begin
    case (reg_addr)
      ADDR_STRAP: reg_rdata = {done_q, strap_q, 10'b0};
      ADDR_BMCR:  reg_rdata = bmcr_q;
      ADDR_ANAR:  reg_rdata = anar_q;
      ADDR_PHYCR: reg_rdata = phycr_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_strap_cfg_ctrl.sv
module sim_strap_cfg_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_ovr = 1'b0;
  logic [15:0] pin_bmcr = '0, pin_anar = '0, pin_phycr = '0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, bmcr_q, anar_q, phycr_q;
  logic core_rst_hold, int_rst_pulse;

  int compared = 0;
  int mismatched = 0;
  int pulse_cnt = 0;

  always #10 clk = ~clk;

  strap_cfg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_ovr(strap_ovr),
    .pin_bmcr(pin_bmcr), .pin_anar(pin_anar), .pin_phycr(pin_phycr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_rst_hold(core_rst_hold), .int_rst_pulse(int_rst_pulse),
    .bmcr_q(bmcr_q), .anar_q(anar_q), .phycr_q(phycr_q)
  );

  always @(negedge clk) if (int_rst_pulse) pulse_cnt++;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset(logic ovr, logic [15:0] pb, logic [15:0] pa, logic [15:0] pp);
    @(negedge clk);
    rst_n = 1'b0; strap_ovr = ovr; pin_bmcr = pb; pin_anar = pa; pin_phycr = pp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] d, eb, ea, ep, pb, pa, pp;
    for (int ov = 0; ov < 2; ov++) begin
      for (int k = 0; k < 8; k++) begin
        logic an, mdix, led;
        logic [1:0] m;
        an = k[2]; m = k[1:0];
        mdix = ~k[0]; led = k[1] ^ ov[0];
        pb = 16'h0000 ^ (16'h1111 * k[15:0]) ^ (ov[0] ? 16'h3100 : 16'h0000);
        pa = 16'h01E0 ^ (16'h0123 * k[15:0]);
        pp = 16'h8020 ^ (16'h0F0F * k[15:0]);
        // R10: every case begins with a fresh hardware reset that re-arms the sequence
        do_reset(ov[0], pb, pa, pp);
        rd(5'h09, d); check("R1 strap reset value", d, 16'h7C00);
        check("R1 hold", {15'b0, core_rst_hold}, 16'h1);
        check("R1 pulse", {15'b0, int_rst_pulse}, 16'h0);
        check("R1 bmcr", bmcr_q, pb);
        check("R1 anar", anar_q, pa);
        check("R1 phycr", phycr_q, pp);

        pulse_cnt = 0;
        wr(5'h09, {1'b0, mdix, an, m, led, 10'h3FF});
        rd(5'h09, d); check("R2 strap readback", d, {1'b0, mdix, an, m, led, 10'h000});
        rd(5'h01, d); check("R2 unmapped read", d, 16'h0000);
        check("R4 hold before done", {15'b0, core_rst_hold}, 16'h1);
        check("R3 no pulse without done", pulse_cnt[15:0], 16'h0);

        wr(5'h09, {1'b1, mdix, an, m, led, 10'h000});
        check("R3 pulse in cycle after write", {15'b0, int_rst_pulse}, 16'h1);
        @(negedge clk);
        check("R3 pulse one cycle", {15'b0, int_rst_pulse}, 16'h0);
        check("R4 hold released", {15'b0, core_rst_hold}, 16'h0);
        repeat (3) @(negedge clk);
        check("R3 exactly one pulse", pulse_cnt[15:0], 16'h1);

        eb = pb; ea = pa; ep = pp;
        if (ov[0]) begin
          eb[12] = an;
          eb[13] = !an && m[1];
          eb[8]  = !an && m[0];
          if (an) begin
            ea[5] = (m != 2'b01);
            ea[6] = (m == 2'b00) || (m == 2'b11);
            ea[7] = (m != 2'b00);
            ea[8] = m[0];
          end
          ep[15] = mdix; ep[5] = led;
        end
        if (!ov[0]) begin
          check("R9 bmcr kept", bmcr_q, eb);
          check("R9 anar kept", anar_q, ea);
          check("R9 phycr kept", phycr_q, ep);
        end else if (an) begin
          check("R7 bmcr negotiation", bmcr_q, eb);
          check("R7 anar advertised", anar_q, ea);
          check("R8 phycr", phycr_q, ep);
        end else begin
          check("R6 bmcr forced", bmcr_q, eb);
          check("R6 anar untouched", anar_q, ea);
          check("R8 phycr", phycr_q, ep);
        end
        rd(5'h00, d); check("R2 bmcr read", d, eb);
        rd(5'h04, d); check("R2 anar read", d, ea);
        rd(5'h19, d); check("R2 phycr read", d, ep);

        wr(5'h09, {1'b1, ~mdix, ~an, ~m, ~led, 10'h000});
        wr(5'h09, 16'h0000);
        repeat (3) @(negedge clk);
        check("R5 no further pulse", pulse_cnt[15:0], 16'h1);
        rd(5'h09, d); check("R5 flag sticky", {15'b0, d[15]}, 16'h1);
        check("R5 bmcr unchanged", bmcr_q, eb);
        check("R5 anar unchanged", anar_q, ea);
        check("R5 phycr unchanged", phycr_q, ep);
        check("R4 hold stays low", {15'b0, core_rst_hold}, 16'h0);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule